// File: doc/BRIEF.md
# Ordered Memory-Decoder Commit Register Bank

This block holds a small array of host address range decoders behind a 32-bit register port. Each decoder has a 64-bit base, a 64-bit size, a control word and a 64-bit auxiliary word. The auxiliary word holds either a packed list of downstream port identifiers or a skip amount, depending on how software uses the decoder. Software programs a decoder and then sets its commit-request bit. After a fixed, parameterised number of clock cycles the block answers with either a committed status or a commit-error status.

Decoders come up strictly in ascending index order and go down strictly in descending order. A single cursor counts the committed decoders and gates both directions. While a decoder's commit-request bit is set, its programming is frozen. When the top decoder is torn down, its base and size are wiped. Per-decoder committed and error flags, plus the cursor, are also driven on output pins for neighbouring logic.

Top module: `ordered_decoder_bank`

## Requirements
- R1: After reset every register reads zero, the cursor (status word at address 0x00, bits [CW-1:0]) is zero, and no committed or error flag is set.
- R2: Decoder i occupies addresses 0x10+0x20*i (base low), +0x04 (base high), +0x08 (size low), +0x0C (size high), +0x10 (control), +0x14 (aux low) and +0x18 (aux high). In the aux word, port identifier k sits in bits [8k+7:8k]. Control bits [7:0] (configuration), bit 8 (lock) and bit 12 (target type, 1 = memory expander) read back as written while the decoder is idle.
- R3: A commit request (control bit 9 written 1) on decoder i, where i equals the cursor and the size is non-zero, sets committed (control bit 10 and the committed pin) exactly LAT cycles after the write edge and increments the cursor.
- R4: A commit request that is out of order or has a zero size sets commit-error (control bit 11) exactly LAT cycles after the write edge. Committed stays clear and the cursor is unchanged.
- R5: A commit request that arrives while another commit is in flight sets commit-error on that decoder at the write edge itself.
- R6: Writing control bit 9 as 0 on a decoder in the error state clears both the error and the request bit at that edge, and leaves the decoder uncommitted.
- R7: Writing control bit 9 as 0 on the highest committed decoder while no commit is in flight does three things at that edge: it clears committed, decrements the cursor and zeroes base and size. The aux word and the other control fields keep their values.
- R8: A teardown of a committed decoder that is not the highest, or any teardown while a commit is in flight, is ignored.
- R9: While a decoder's request bit is set, writes to its base, size, aux and control fields are ignored. Once the request bit has cleared, writes take effect again.
- R10: A commit request repeated on an already committed decoder changes nothing.
- R11: Committed and error are never both set on one decoder, and the committed set is always exactly decoders 0 to cursor-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| committed | output | N | Per-decoder committed flag |
| commitErr | output | N | Per-decoder commit-error flag |
| nextIdx | output | CW | Commit cursor: number of committed decoders |

## Verification
A cursor that has drifted becomes visible at once on nextIdx and in the status word. It then causes the wrong accept or reject of the next commit exactly LAT cycles after that request. A wrong response timer moves the committed or error edge away from the LAT-cycle point, and the bench samples both one cycle before that point and at it. A frozen-field or wipe fault appears on the first read-back after the offending write, and a broken teardown rule appears in the committed pins on the cycle that follows the write.

// File: rtl/odb_pkg.sv
package odb_pkg;
  localparam int B_LOCK = 8;
  localparam int B_REQ  = 9;
  localparam int B_DONE = 10;
  localparam int B_ERR  = 11;
  localparam int B_TYPE = 12;

  localparam logic [2:0] W_BASE_LO = 3'd0;
  localparam logic [2:0] W_BASE_HI = 3'd1;
  localparam logic [2:0] W_SIZE_LO = 3'd2;
  localparam logic [2:0] W_SIZE_HI = 3'd3;
  localparam logic [2:0] W_CTRL    = 3'd4;
  localparam logic [2:0] W_AUX_LO  = 3'd5;
  localparam logic [2:0] W_AUX_HI  = 3'd6;

  // decoded access: status word or per-decoder word index
  typedef struct packed {
    logic       stat;
    logic [2:0] word;
  } acc_t;

  // control -> datapath strobes
  typedef struct packed {
    logic wrOk;   // addressed decoder accepts field writes
    logic wipe;   // clear base/size of addressed decoder
  } dp_strobe_t;
endpackage

// File: rtl/odb_ctrl.sv
module odb_ctrl import odb_pkg::*; #(
  parameter int N   = 4,
  parameter int LAT = 6,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [2:0]     word,
  input  logic [N-1:0]   hitVec,
  input  logic           reqIn,
  input  logic [N-1:0]   sizeNz,
  output dp_strobe_t     stb,
  output logic [N-1:0]   reqBit,
  output logic [N-1:0]   done,
  output logic [N-1:0]   err,
  output logic [CW-1:0]  cnt
);
  localparam int TW = $clog2(LAT + 1);

  logic          busy, busyN;
  logic [N-1:0]  pSel, pSelN;
  logic [TW-1:0] timer, timerN;
  logic [N-1:0]  reqN, doneN, errN;
  logic [CW-1:0] cntN;
  logic [N:0]    nxt;
  logic ctrlWr, selReq, selDone, selErr;
  logic startReq, dropReq, tearOk, clrErr, finOk;

  always_comb begin
    nxt      = (N+1)'(1) << cnt;
    ctrlWr   = wrEn && (word == W_CTRL) && (|hitVec);
    selReq   = |(hitVec & reqBit);
    selDone  = |(hitVec & done);
    selErr   = |(hitVec & err);
    startReq = ctrlWr && reqIn && !selReq;
    dropReq  = ctrlWr && !reqIn && selReq;
    tearOk   = dropReq && selDone && !busy && ({hitVec, 1'b0} == nxt);
    clrErr   = dropReq && selErr;
    finOk    = ({1'b0, pSel} == nxt) && (|(pSel & sizeNz));
    stb.wrOk = wrEn && !selReq;
    stb.wipe = tearOk;
  end

  always_comb begin
    reqN = reqBit; doneN = done; errN = err; cntN = cnt;
    busyN = busy; pSelN = pSel; timerN = timer;
    if (busy) begin
      if (timer == '0) begin
        busyN = 1'b0;
        if (finOk) begin
          doneN = doneN | pSel;
          cntN  = cnt + CW'(1);
        end else begin
          errN = errN | pSel;
        end
      end else begin
        timerN = timer - TW'(1);
      end
    end
    if (startReq) begin
      reqN = reqN | hitVec;
      if (busy) errN = errN | hitVec;
      else begin
        busyN  = 1'b1;
        pSelN  = hitVec;
        timerN = TW'(LAT - 1);
      end
    end
    if (clrErr) begin
      errN = errN & ~hitVec;
      reqN = reqN & ~hitVec;
    end
    if (tearOk) begin
      doneN = doneN & ~hitVec;
      reqN  = reqN & ~hitVec;
      cntN  = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBit <= '0; done <= '0; err <= '0; cnt <= '0;
      busy <= 1'b0; pSel <= '0; timer <= '0;
    end else begin
      reqBit <= reqN; done <= doneN; err <= errN; cnt <= cntN;
      busy <= busyN; pSel <= pSelN; timer <= timerN;
    end
  end
endmodule

// File: rtl/odb_datapath.sv
module odb_datapath import odb_pkg::*; #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  acc_t          acc,
  input  logic [N-1:0]  hitVec,
  input  logic [31:0]   wrData,
  input  dp_strobe_t    stb,
  input  logic [N-1:0]  reqBit,
  input  logic [N-1:0]  done,
  input  logic [N-1:0]  err,
  input  logic [CW-1:0] cnt,
  output logic [N-1:0]  sizeNz,
  output logic [31:0]   rdData
);
  logic [31:0] baseLo [N];
  logic [31:0] baseHi [N];
  logic [31:0] sizeLo [N];
  logic [31:0] sizeHi [N];
  logic [31:0] auxLo  [N];
  logic [31:0] auxHi  [N];
  logic [7:0]  cfg    [N];
  logic [N-1:0] lockB, typB;

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rstN) begin
        baseLo[i] <= '0; baseHi[i] <= '0; sizeLo[i] <= '0; sizeHi[i] <= '0;
        auxLo[i] <= '0; auxHi[i] <= '0; cfg[i] <= '0;
        lockB[i] <= 1'b0; typB[i] <= 1'b0;
      end else if (stb.wipe && hitVec[i]) begin
        baseLo[i] <= '0; baseHi[i] <= '0; sizeLo[i] <= '0; sizeHi[i] <= '0;
      end else if (stb.wrOk && hitVec[i]) begin
        case (acc.word)
          W_BASE_LO: baseLo[i] <= wrData;
          W_BASE_HI: baseHi[i] <= wrData;
          W_SIZE_LO: sizeLo[i] <= wrData;
          W_SIZE_HI: sizeHi[i] <= wrData;
          W_AUX_LO:  auxLo[i]  <= wrData;
          W_AUX_HI:  auxHi[i]  <= wrData;
          W_CTRL: begin
            cfg[i]   <= wrData[7:0];
            lockB[i] <= wrData[B_LOCK];
            typB[i]  <= wrData[B_TYPE];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) sizeNz[i] = |{sizeHi[i], sizeLo[i]};
  end

  always_comb begin
    rdData = '0;
    if (acc.stat) rdData = 32'(cnt);
    for (int i = 0; i < N; i++) begin
      if (hitVec[i]) begin
        case (acc.word)
          W_BASE_LO: rdData = baseLo[i];
          W_BASE_HI: rdData = baseHi[i];
          W_SIZE_LO: rdData = sizeLo[i];
          W_SIZE_HI: rdData = sizeHi[i];
          W_AUX_LO:  rdData = auxLo[i];
          W_AUX_HI:  rdData = auxHi[i];
          W_CTRL:    rdData = {19'b0, typB[i], err[i], done[i], reqBit[i], lockB[i], cfg[i]};
          default:   rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ordered_decoder_bank.sv
module ordered_decoder_bank import odb_pkg::*; #(
  parameter int N      = 4,
  parameter int LAT    = 6,
  parameter int ADDR_W = 10,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [N-1:0]      committed,
  output logic [N-1:0]      commitErr,
  output logic [CW-1:0]     nextIdx
);
  acc_t              acc;
  logic [N-1:0]      hitVec;
  logic [ADDR_W-1:0] rel;
  dp_strobe_t        stb;
  logic [N-1:0]      reqBit, done, err, sizeNz;
  logic [CW-1:0]     cnt;

  always_comb begin
    rel      = addr - ADDR_W'(16);
    acc.stat = (addr == '0);
    acc.word = rel[4:2];
    hitVec   = '0;
    if (addr >= ADDR_W'(16) && rel[1:0] == 2'b00 && rel[4:2] <= W_AUX_HI)
      for (int i = 0; i < N; i++)
        if (int'(rel[ADDR_W-1:5]) == i) hitVec[i] = 1'b1;
  end

  odb_ctrl #(.N(N), .LAT(LAT), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .word(acc.word), .hitVec(hitVec),
    .reqIn(wrData[B_REQ]), .sizeNz(sizeNz), .stb(stb),
    .reqBit(reqBit), .done(done), .err(err), .cnt(cnt)
  );

  odb_datapath #(.N(N), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .acc(acc), .hitVec(hitVec), .wrData(wrData),
    .stb(stb), .reqBit(reqBit), .done(done), .err(err), .cnt(cnt),
    .sizeNz(sizeNz), .rdData(rdData)
  );

  assign committed = done;
  assign commitErr = err;
  assign nextIdx   = cnt;
endmodule

// File: rtl/odb_chk.sv
module odb_chk #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  committed,
  input logic [N-1:0]  commitErr,
  input logic [CW-1:0] nextIdx
);
  logic [N:0] prefix;
  assign prefix = ((N+1)'(1) << nextIdx) - (N+1)'(1);

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (committed & commitErr) == '0);

  // R11
  prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, committed} == prefix);

  // R3
  rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(committed & ~$past(committed))) |-> (int'(nextIdx) == int'($past(nextIdx)) + 1));

  // R7
  fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(~committed & $past(committed))) |-> (int'(nextIdx) == int'($past(nextIdx)) - 1));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (committed == $past(committed)) |-> $stable(nextIdx));
endmodule

bind ordered_decoder_bank odb_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .committed(committed),
  .commitErr(commitErr), .nextIdx(nextIdx)
);

// File: tb/test_ordered_decoder_bank.sv
module test_ordered_decoder_bank;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int LAT   = 6;
  localparam int AW    = 10;
  localparam int CW    = $clog2(N + 1);

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [N-1:0] committed, commitErr;
  logic [CW-1:0] nextIdx;
  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ordered_decoder_bank #(.N(N), .LAT(LAT), .ADDR_W(AW)) i_ordered_decoder_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .committed(committed), .commitErr(commitErr), .nextIdx(nextIdx)
  );

  typedef struct packed { logic wr; logic [9:0] a; logic [31:0] d; } vec_t;
  localparam vec_t VEC [16] = '{
    '{1'b1, 10'h010, 32'hA000_0000}, '{1'b1, 10'h014, 32'h0000_0003},
    '{1'b1, 10'h018, 32'h1000_0000}, '{1'b1, 10'h01C, 32'h0000_0000},
    '{1'b1, 10'h024, 32'h0403_0201}, '{1'b1, 10'h028, 32'h0807_0605},
    '{1'b1, 10'h020, 32'h0000_11A5}, '{1'b1, 10'h038, 32'h0000_0100},
    '{1'b0, 10'h010, 32'hA000_0000}, '{1'b0, 10'h014, 32'h0000_0003},
    '{1'b0, 10'h018, 32'h1000_0000}, '{1'b0, 10'h024, 32'h0403_0201},
    '{1'b0, 10'h028, 32'h0807_0605}, '{1'b0, 10'h020, 32'h0000_11A5},
    '{1'b0, 10'h038, 32'h0000_0100}, '{1'b0, 10'h000, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 committed", 32'(committed), 32'h0);
    chk("R1 err", 32'(commitErr), 32'h0);
    chk("R1 cursor", 32'(nextIdx), 32'h0);
    rdChk("R1 status", 10'h000, 32'h0);
    rdChk("R1 ctrl0", 10'h020, 32'h0);
    rdChk("R1 base0", 10'h010, 32'h0);

    // R2 register map through the vector table
    for (int k = 0; k < 16; k++) begin
      if (VEC[k].wr) wr(VEC[k].a, VEC[k].d);
      else rdChk("R2 readback", VEC[k].a, VEC[k].d);
    end

    // R4 out of order: decoder 1 before decoder 0
    wr(10'h040, 32'h200);
    waitCyc(LAT - 1);
    chk("R4 early err", 32'(commitErr), 32'h0);
    waitCyc(1);
    chk("R4 err", 32'(commitErr), 32'h2);
    chk("R4 committed", 32'(committed), 32'h0);
    chk("R4 cursor", 32'(nextIdx), 32'h0);
    // R6 clear after error
    wr(10'h040, 32'h0);
    chk("R6 err cleared", 32'(commitErr), 32'h0);
    chk("R6 uncommitted", 32'(committed), 32'h0);
    rdChk("R6 ctrl1", 10'h040, 32'h0);

    // R4 zero size on decoder 2 (also out of order)
    wr(10'h060, 32'h200);
    waitCyc(LAT);
    chk("R4 zero size err", 32'(commitErr), 32'h4);
    wr(10'h060, 32'h0);
    chk("R6 err2 cleared", 32'(commitErr), 32'h0);

    // R3 in-order commit of decoder 0, exact latency
    wr(10'h020, 32'h13A5);
    waitCyc(LAT - 1);
    chk("R3 early committed", 32'(committed), 32'h0);
    waitCyc(1);
    chk("R3 committed", 32'(committed), 32'h1);
    chk("R3 cursor", 32'(nextIdx), 32'h1);
    rdChk("R3 ctrl0", 10'h020, 32'h17A5);
    rdChk("R3 status", 10'h000, 32'h1);

    // R9 frozen fields while committed
    wr(10'h010, 32'hDEAD);
    rdChk("R9 base frozen", 10'h010, 32'hA000_0000);
    wr(10'h018, 32'h0);
    rdChk("R9 size frozen", 10'h018, 32'h1000_0000);
    // R10 repeated commit
    wr(10'h020, 32'h200);
    rdChk("R10 ctrl0", 10'h020, 32'h17A5);
    chk("R10 cursor", 32'(nextIdx), 32'h1);
    chk("R10 err", 32'(commitErr), 32'h0);

    // R5 request while decoder 1 commit in flight
    wr(10'h040, 32'h200);
    wr(10'h060, 32'h200);
    chk("R5 busy err", 32'(commitErr), 32'h4);
    // R8 teardown while busy ignored
    wr(10'h020, 32'h0);
    chk("R8 busy teardown", 32'(committed), 32'h1);
    waitCyc(LAT);
    chk("R3 second committed", 32'(committed), 32'h3);
    chk("R3 second cursor", 32'(nextIdx), 32'h2);
    wr(10'h060, 32'h0);
    rdChk("R6 ctrl2", 10'h060, 32'h0);

    // R8 teardown of non-top decoder ignored
    wr(10'h020, 32'h11A5);
    chk("R8 non-top", 32'(committed), 32'h3);
    rdChk("R8 ctrl0", 10'h020, 32'h17A5);

    // R7 teardown in descending order
    wr(10'h040, 32'h0);
    chk("R7 committed", 32'(committed), 32'h1);
    chk("R7 cursor", 32'(nextIdx), 32'h1);
    rdChk("R7 size1 wiped", 10'h038, 32'h0);
    wr(10'h020, 32'h0);
    chk("R7 committed0", 32'(committed), 32'h0);
    chk("R7 cursor0", 32'(nextIdx), 32'h0);
    rdChk("R7 base0 wiped", 10'h010, 32'h0);
    rdChk("R7 size0 wiped", 10'h018, 32'h0);
    rdChk("R7 aux kept", 10'h024, 32'h0403_0201);
    rdChk("R7 ctrl kept", 10'h020, 32'h11A5);

    // R9 writes open again
    wr(10'h010, 32'h5);
    rdChk("R9 reopen", 10'h010, 32'h5);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule